// File: doc/BRIEF.md
# Shared-Pin I2C/SPI Register Slave

This block gives an external host access to a small internal register bank over either an I2C slave or an SPI slave. Both protocols share one set of pins: a chip-select input, a serial clock pin used as SCL or SPC, a bidirectional data pin used as SDA or as the SPI data line, and a fourth pin that is either the SPI data output or the I2C address low bit. The level of chip-select decides which engine owns the pins. A high level leaves SPI idle and lets I2C run. A low level starts an SPI transfer and silences I2C.

A control register inside the bank holds two mode bits. One turns the I2C engine off for good, so that only SPI remains usable. The other moves SPI read data from the dedicated output pin onto the shared data pin, which gives a 3-wire port. All serial inputs pass through a synchronizer and are oversampled by the system clock, which must run at least 8 times faster than the fastest serial clock. The data pin is driven through separate value and enable outputs, so that the pad and the external pull-up sit outside the block.

Top module: `dual_serial_regbank`

## Requirements
- R1: After reset every register reads 0x00, and neither the data pin nor the SDO pin is driven while chip-select is high.
- R2: With chip-select high, I2C owns the pins. While chip-select is low, I2C start and stop conditions are ignored and I2C writes nothing. An I2C byte that is cut off by chip-select going low writes no register.
- R3: The I2C slave address is the 6-bit parameter I2C_PREFIX followed by the level sampled on the SDO/SA0 pin. The block ACKs only a matching address byte, whose bit 0 is R/W with 1 meaning read.
- R4: An I2C write takes a sub-address byte, whose low 7 bits set the register pointer. Each data byte after it is written and ACKed, and the pointer then increments.
- R5: An I2C read after a repeated start returns register data MSB first from the current pointer. The pointer increments after each byte, a master ACK continues the burst, and a master NACK ends it.
- R6: On the I2C side the block only pulls the data pin low; it never drives it high.
- R7: SPI runs in mode 3. The first bit after chip-select falls is R/W (1 = read), the next 7 bits are the register address, data bytes follow MSB first, and the address increments after every byte while chip-select stays low.
- R8: When bit 3 of register 0x23 is 0 (4-wire mode), the SDO pin is driven only while chip-select is low and carries the read data.
- R9: When bit 3 of register 0x23 is 1 (3-wire mode), the SDO pin is never driven. Read data appears on the shared data pin, which is driven only during the read data phase and is released when chip-select rises.
- R10: Raising chip-select partway through an SPI data byte writes nothing for that byte. Bytes completed before it remain written.
- R11: When bit 2 of register 0x23 is 1, the I2C engine is off: it ACKs nothing and writes nothing, while SPI keeps working.
- R12: In any cycle at most one protocol engine issues a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip-select; high selects I2C, low runs SPI |
| sclk_i | input | 1 | SCL in I2C mode, SPC in SPI mode |
| sda_i | input | 1 | Level seen on the shared data pin |
| sda_o | output | 1 | Value driven on the shared data pin |
| sda_oe_o | output | 1 | Drive enable for the shared data pin |
| sdo_sa0_i | input | 1 | Level seen on the SDO/SA0 pin (I2C address bit 0) |
| sdo_o | output | 1 | SPI read data on the SDO pin |
| sdo_oe_o | output | 1 | Drive enable for the SDO pin |

## Verification
An I2C transaction and an SPI transfer can overlap: chip-select can fall while an I2C data byte is half shifted in, so the SPI engine starts on the same clock pin while the I2C engine is still mid-byte. The bench provokes this by stopping an I2C burst after four data bits, pulling chip-select low and running a full SPI write to a neighbouring register. It then judges the result from the registers read back over SPI: the SPI byte must land, the cut-off I2C byte must not, and a later I2C byte sent without a new start must get no ACK. A checker also requires that the two write strobes are never high together.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int unsigned AW = 7;
  localparam int unsigned DW = 8;
  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] byte_t;
  typedef enum logic [3:0] {
    I_IDLE, I_ADDR, I_AACK, I_SUB, I_SACK, I_WDAT, I_WACK, I_RDAT, I_RACK
  } i2c_st_e;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pipe[s] <= RST_VAL;
      else if (s == 0) pipe[s] <= d_i;
      else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/dsr_regbank.sv
module dsr_regbank
  import dsr_pkg::*;
#(
  parameter addr_t       CTRL_ADDR = 7'h23,
  parameter int unsigned DIS_BIT   = 2,
  parameter int unsigned W3_BIT    = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  addr_t waddr_i,
  input  byte_t wdata_i,
  input  addr_t raddr_i,
  output byte_t rdata_o,
  output logic  i2c_dis_o,
  output logic  wire3_o
);
  localparam int unsigned NREG = 1 << AW;
  byte_t regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs[g] <= '0;
      else if (we_i && waddr_i == addr_t'(g)) regs[g] <= wdata_i;
    end
  end

  assign rdata_o   = regs[raddr_i];
  assign i2c_dis_o = regs[CTRL_ADDR][DIS_BIT];
  assign wire3_o   = regs[CTRL_ADDR][W3_BIT];
endmodule

// File: rtl/dsr_i2c_slave.sv
module dsr_i2c_slave
  import dsr_pkg::*;
#(
  parameter logic [5:0] PREFIX = 6'b101100
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  scl_i,
  input  logic  scl_prev_i,
  input  logic  sda_i,
  input  logic  sda_prev_i,
  input  logic  sa0_i,
  input  byte_t rd_data_i,
  output addr_t rd_addr_o,
  output logic  we_o,
  output addr_t waddr_o,
  output byte_t wdata_o,
  output logic  pull_o
);
  i2c_st_e    st_q;
  logic [3:0] cnt_q;
  byte_t      sh_q, wdata_q;
  addr_t      ptr_q, waddr_q;
  logic       rw_q, mack_q, drv_q, we_q;

  logic scl_rise, scl_fall, start, stop;
  assign scl_rise = scl_i & ~scl_prev_i;
  assign scl_fall = ~scl_i & scl_prev_i;
  assign start    = scl_i & scl_prev_i & sda_prev_i & ~sda_i;
  assign stop     = scl_i & scl_prev_i & ~sda_prev_i & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= I_IDLE; cnt_q <= '0; sh_q <= '0; ptr_q <= '0;
      rw_q <= 1'b0; mack_q <= 1'b0; drv_q <= 1'b0;
      we_q <= 1'b0; waddr_q <= '0; wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (!en_i) begin
        st_q <= I_IDLE; drv_q <= 1'b0; cnt_q <= '0;
      end else if (start) begin
        st_q <= I_ADDR; drv_q <= 1'b0; cnt_q <= '0;
      end else if (stop) begin
        st_q <= I_IDLE; drv_q <= 1'b0;
      end else begin
        case (st_q)
          I_ADDR, I_SUB, I_WDAT: begin
            if (scl_rise && cnt_q != 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              cnt_q <= '0;
              drv_q <= 1'b1;
              if (st_q == I_ADDR) begin
                if (sh_q[7:1] == {PREFIX, sa0_i}) begin
                  rw_q <= sh_q[0];
                  st_q <= I_AACK;
                end else begin
                  drv_q <= 1'b0;
                  st_q  <= I_IDLE;
                end
              end else if (st_q == I_SUB) begin
                ptr_q <= sh_q[AW-1:0];
                st_q  <= I_SACK;
              end else begin
                we_q    <= 1'b1;
                waddr_q <= ptr_q;
                wdata_q <= sh_q;
                ptr_q   <= ptr_q + addr_t'(1);
                st_q    <= I_WACK;
              end
            end
          end
          I_AACK, I_SACK, I_WACK: begin
            if (scl_fall) begin
              drv_q <= 1'b0;
              cnt_q <= '0;
              if (st_q == I_AACK && rw_q) begin
                sh_q  <= rd_data_i;
                ptr_q <= ptr_q + addr_t'(1);
                drv_q <= ~rd_data_i[7];
                st_q  <= I_RDAT;
              end else if (st_q == I_AACK) begin
                st_q <= I_SUB;
              end else begin
                st_q <= I_WDAT;
              end
            end
          end
          I_RDAT: begin
            if (scl_fall) begin
              if (cnt_q == 4'd7) begin
                drv_q <= 1'b0;
                st_q  <= I_RACK;
              end else begin
                sh_q  <= {sh_q[6:0], 1'b0};
                drv_q <= ~sh_q[6];
                cnt_q <= cnt_q + 4'd1;
              end
            end
          end
          I_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_i;
            end else if (scl_fall) begin
              if (mack_q) begin
                sh_q  <= rd_data_i;
                ptr_q <= ptr_q + addr_t'(1);
                drv_q <= ~rd_data_i[7];
                cnt_q <= '0;
                st_q  <= I_RDAT;
              end else begin
                st_q <= I_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = ptr_q;
  assign we_o      = we_q;
  assign waddr_o   = waddr_q;
  assign wdata_o   = wdata_q;
  assign pull_o    = drv_q & en_i;
endmodule

// File: rtl/dsr_spi_slave.sv
module dsr_spi_slave
  import dsr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_i,
  input  logic  sck_i,
  input  logic  sck_prev_i,
  input  logic  sdi_i,
  input  byte_t rd_data_i,
  output addr_t rd_addr_o,
  output logic  we_o,
  output addr_t waddr_o,
  output byte_t wdata_o,
  output logic  rd_phase_o,
  output logic  tx_o
);
  logic [2:0] cnt_q;
  logic [6:0] rx_q;
  byte_t      tx_q, wdata_q;
  addr_t      addr_q, waddr_q, cmd_addr;
  logic       in_cmd_q, rd_q, we_q, sck_rise;

  assign sck_rise = sck_i & ~sck_prev_i;
  assign cmd_addr = {rx_q[5:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; rx_q <= '0; tx_q <= '0; addr_q <= '0;
      in_cmd_q <= 1'b1; rd_q <= 1'b0;
      we_q <= 1'b0; waddr_q <= '0; wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (cs_i) begin
        in_cmd_q <= 1'b1; cnt_q <= '0; rd_q <= 1'b0;
      end else if (sck_rise) begin
        rx_q  <= {rx_q[5:0], sdi_i};
        cnt_q <= cnt_q + 3'd1;
        if (in_cmd_q) begin
          if (cnt_q == 3'd7) begin
            in_cmd_q <= 1'b0;
            rd_q     <= rx_q[6];
            addr_q   <= cmd_addr;
            tx_q     <= rd_data_i;
          end
        end else if (rd_q) begin
          if (cnt_q == 3'd7) begin
            addr_q <= addr_q + addr_t'(1);
            tx_q   <= rd_data_i;
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end else if (cnt_q == 3'd7) begin
          we_q    <= 1'b1;
          waddr_q <= addr_q;
          wdata_q <= {rx_q, sdi_i};
          addr_q  <= addr_q + addr_t'(1);
        end
      end
    end
  end

  assign rd_addr_o  = in_cmd_q ? cmd_addr : addr_q + addr_t'(1);
  assign we_o       = we_q;
  assign waddr_o    = waddr_q;
  assign wdata_o    = wdata_q;
  assign rd_phase_o = ~in_cmd_q & rd_q;
  assign tx_o       = tx_q[7];
endmodule

// File: rtl/dual_serial_regbank.sv
module dual_serial_regbank
  import dsr_pkg::*;
#(
  parameter logic [5:0]  I2C_PREFIX  = 6'b101100,
  parameter addr_t       CTRL_ADDR   = 7'h23,
  parameter int unsigned DIS_BIT     = 2,
  parameter int unsigned W3_BIT      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_oe_o,
  input  logic sdo_sa0_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic [3:0] sync_q;
  logic cs_s, scl_s, sda_s, sa0_s, scl_prev_q, sda_prev_q;

  dsr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_i, sclk_i, sda_i, sdo_sa0_i}),
    .q_o (sync_q)
  );
  assign {cs_s, scl_s, sda_s, sa0_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  logic  i2c_dis, wire3, i2c_en;
  logic  i2c_we, spi_we, i2c_pull, spi_rd_phase, spi_tx;
  addr_t i2c_waddr, spi_waddr, i2c_raddr, spi_raddr, raddr, waddr;
  byte_t i2c_wdata, spi_wdata, rdata, wdata;

  assign i2c_en = cs_s & ~i2c_dis;

  dsr_i2c_slave #(.PREFIX(I2C_PREFIX)) u_i2c (
    .clk_i, .rst_ni,
    .en_i       (i2c_en),
    .scl_i      (scl_s),
    .scl_prev_i (scl_prev_q),
    .sda_i      (sda_s),
    .sda_prev_i (sda_prev_q),
    .sa0_i      (sa0_s),
    .rd_data_i  (rdata),
    .rd_addr_o  (i2c_raddr),
    .we_o       (i2c_we),
    .waddr_o    (i2c_waddr),
    .wdata_o    (i2c_wdata),
    .pull_o     (i2c_pull)
  );

  dsr_spi_slave u_spi (
    .clk_i, .rst_ni,
    .cs_i       (cs_s),
    .sck_i      (scl_s),
    .sck_prev_i (scl_prev_q),
    .sdi_i      (sda_s),
    .rd_data_i  (rdata),
    .rd_addr_o  (spi_raddr),
    .we_o       (spi_we),
    .waddr_o    (spi_waddr),
    .wdata_o    (spi_wdata),
    .rd_phase_o (spi_rd_phase),
    .tx_o       (spi_tx)
  );

  assign raddr = cs_s ? i2c_raddr : spi_raddr;
  assign waddr = spi_we ? spi_waddr : i2c_waddr;
  assign wdata = spi_we ? spi_wdata : i2c_wdata;

  dsr_regbank #(.CTRL_ADDR(CTRL_ADDR), .DIS_BIT(DIS_BIT), .W3_BIT(W3_BIT)) u_bank (
    .clk_i, .rst_ni,
    .we_i      (i2c_we | spi_we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_i   (raddr),
    .rdata_o   (rdata),
    .i2c_dis_o (i2c_dis),
    .wire3_o   (wire3)
  );

  // raw cs gates the pads so release follows cs without sync delay
  logic i2c_drv, spi3_drv;
  assign i2c_drv  = i2c_pull & cs_i;
  assign spi3_drv = ~cs_i & wire3 & spi_rd_phase;
  assign sda_oe_o = i2c_drv | spi3_drv;
  assign sda_o    = i2c_drv ? 1'b0 : spi_tx;
  assign sdo_oe_o = ~cs_i & ~wire3;
  assign sdo_o    = spi_rd_phase ? spi_tx : 1'b0;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic cs_s_i,
  input logic sda_oe_i,
  input logic sda_i,
  input logic sdo_oe_i,
  input logic i2c_we_i,
  input logic spi_we_i,
  input logic i2c_dis_i
);
  assert_i2c_open_drain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && sda_oe_i) |-> !sda_i);

  assert_single_writer_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({i2c_we_i, spi_we_i}));

  assert_spi_write_in_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_we_i |-> $past(!cs_s_i));

  assert_i2c_write_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i2c_we_i |-> $past(cs_s_i));

  assert_i2c_off_silent_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i2c_dis_i && $past(i2c_dis_i)) |-> (!i2c_we_i && !(cs_i && sda_oe_i)));

  assert_pin_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i && !cs_i) |-> !sdo_oe_i);
endmodule

bind dual_serial_regbank dsr_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_i      (cs_i),
  .cs_s_i    (cs_s),
  .sda_oe_i  (sda_oe_o),
  .sda_i     (sda_o),
  .sdo_oe_i  (sdo_oe_o),
  .i2c_we_i  (i2c_we),
  .spi_we_i  (spi_we),
  .i2c_dis_i (i2c_dis)
);

// File: tb/dual_serial_regbank_tb.sv
module dual_serial_regbank_tb;
  localparam logic [5:0] PREFIX = 6'b101100;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b1, scl = 1'b1, tb_drv = 1'b0, tb_val = 1'b1, tb_sa0 = 1'b0;
  logic sda_o, sda_oe, sdo_o, sdo_oe, sda_line, sdo_line;
  logic wire3_tb = 1'b0;
  logic done = 1'b0;
  int   nchk = 0, nfail = 0;
  logic [7:0] exp_mem [128];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #5 clk = ~clk;

  assign sda_line = (sda_oe ? sda_o : 1'b1) & (tb_drv ? tb_val : 1'b1);
  assign sdo_line = sdo_oe ? sdo_o : tb_sa0;

  dual_serial_regbank #(.I2C_PREFIX(PREFIX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(scl),
    .sda_i(sda_line), .sda_o(sda_o), .sda_oe_o(sda_oe),
    .sdo_sa0_i(sdo_line), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 29 + k * 83 + 17) & 255);
  endfunction

  // ---------------- I2C master ----------------
  task automatic i2c_start();
    tb_drv = 1'b0; hw(); scl = 1'b1; hw();
    tb_drv = 1'b1; tb_val = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic i2c_stop();
    tb_drv = 1'b1; tb_val = 1'b0; hw(); scl = 1'b1; hw(); tb_drv = 1'b0; hw();
  endtask

  task automatic i2c_bit(input logic b);
    tb_drv = ~b; tb_val = 1'b0; hw(); scl = 1'b1; hw(); scl = 1'b0;
  endtask

  task automatic i2c_wr(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) i2c_bit(b[i]);
    tb_drv = 1'b0; hw(); scl = 1'b1; hw(); ack = ~sda_line; scl = 1'b0; hw();
  endtask

  task automatic i2c_rd(input logic mack, output logic [7:0] b);
    tb_drv = 1'b0;
    for (int i = 0; i < 8; i++) begin
      hw(); scl = 1'b1; hw(); b = {b[6:0], sda_line}; scl = 1'b0;
    end
    tb_drv = mack; tb_val = 1'b0; hw(); scl = 1'b1; hw(); scl = 1'b0;
  endtask

  // ---------------- SPI master (mode 3) ----------------
  task automatic spi_bit(input logic b, input logic drive, output logic got);
    scl = 1'b0; tb_drv = drive; tb_val = b; hw();
    got = wire3_tb ? sda_line : sdo_line;
    scl = 1'b1; hw();
  endtask

  task automatic spi_frame(input logic rd, input logic [6:0] a, input int nbits);
    logic [7:0] cmd;
    logic g;
    cmd = {rd, a};
    scl = 1'b1; cs = 1'b0; hw();
    for (int i = 7; i >= 0; i--) spi_bit(cmd[i], 1'b1, g);
    for (int j = 0; j < nbits; j++) begin
      spi_bit(wbuf[j/8][7 - j%8], ~rd, g);
      if (rd) rbuf[j/8] = {rbuf[j/8][6:0], g};
    end
    tb_drv = 1'b0; hw(); cs = 1'b1; hw(); hw();
  endtask

  task automatic spi_write(input logic [6:0] a, input int n);
    spi_frame(1'b0, a, n * 8);
    for (int k = 0; k < n; k++) exp_mem[7'(a + k)] = wbuf[k];
  endtask

  task automatic spi_check(input string req, input logic [6:0] a, input int n);
    spi_frame(1'b1, a, n * 8);
    for (int k = 0; k < n; k++) check(req, rbuf[k], exp_mem[7'(a + k)]);
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 sda_oe", sda_oe, 0);
    check("R1 sdo_oe", sdo_oe, 0);
    spi_check("R1 reset value", 7'h20, 8);

    // R3/R4/R5 I2C bursts at both SA0 levels
    for (int s = 0; s < 2; s++) begin
      tb_sa0 = s[0];
      i2c_start();
      i2c_wr({PREFIX, s[0], 1'b0}, ack); check("R3 addr ack", ack, 1);
      i2c_wr(8'(s * 16), ack);           check("R4 sub ack", ack, 1);
      for (int k = 0; k < 16; k++) begin
        i2c_wr(pat(s * 16 + k, s), ack); check("R4 data ack", ack, 1);
        exp_mem[s * 16 + k] = pat(s * 16 + k, s);
      end
      i2c_stop();
      i2c_start();
      i2c_wr({PREFIX, s[0], 1'b0}, ack);
      i2c_wr(8'(s * 16), ack);
      i2c_start();
      i2c_wr({PREFIX, s[0], 1'b1}, ack); check("R3 read addr ack", ack, 1);
      for (int k = 0; k < 16; k++) begin
        i2c_rd(k != 15, b);
        check("R5 read data", b, exp_mem[s * 16 + k]);
      end
      i2c_stop();
      i2c_start();
      i2c_wr({PREFIX, ~s[0], 1'b0}, ack); check("R3 wrong addr nack", ack, 0);
      i2c_stop();
    end

    // R7/R8 SPI 4-wire
    tb_sa0 = 1'b0;
    spi_check("R8 4-wire read", 7'h00, 16);
    for (int k = 0; k < 8; k++) wbuf[k] = pat(k, 2);
    spi_write(7'h40, 8);
    spi_check("R7 burst readback", 7'h40, 8);
    cs = 1'b0; hw();
    check("R8 sdo driven", sdo_oe, 1);
    cs = 1'b1; hw(); hw();
    check("R8 sdo released", sdo_oe, 0);

    // R2/R12 SPI frame cuts into an I2C byte
    i2c_start();
    i2c_wr({PREFIX, 1'b0, 1'b0}, ack);
    i2c_wr(8'h50, ack);
    i2c_wr(8'h11, ack); exp_mem[8'h50] = 8'h11;
    for (int i = 0; i < 4; i++) i2c_bit(1'b1);
    wbuf[0] = 8'h5A;
    spi_write(7'h52, 1);
    spi_check("R12 overlap regs", 7'h50, 3);
    i2c_wr({PREFIX, 1'b0, 1'b0}, ack); check("R2 no ack without start", ack, 0);
    i2c_stop();

    // R2 start condition while cs low is ignored
    cs = 1'b0; hw(); tb_drv = 1'b1; tb_val = 1'b0; hw(); hw();
    cs = 1'b1; hw(); hw(); scl = 1'b0; hw();
    i2c_wr({PREFIX, 1'b0, 1'b0}, ack); check("R2 start ignored", ack, 0);
    i2c_stop();

    // R10 abort mid-byte
    wbuf[0] = 8'h3C; wbuf[1] = 8'hFF;
    spi_frame(1'b0, 7'h60, 13);
    exp_mem[8'h60] = 8'h3C;
    spi_check("R10 abort", 7'h60, 2);

    // R9 3-wire mode
    wbuf[0] = 8'h08;
    spi_write(7'h23, 1);
    wire3_tb = 1'b1;
    spi_check("R9 ctrl readback", 7'h23, 1);
    cs = 1'b0; hw();
    check("R9 sdo idle", sdo_oe, 0);
    cs = 1'b1; hw();
    spi_check("R9 3-wire read", 7'h10, 16);
    check("R9 sda released", sda_oe, 0);
    for (int k = 0; k < 4; k++) wbuf[k] = pat(k, 3);
    spi_write(7'h70, 4);
    spi_check("R9 3-wire write", 7'h70, 4);

    // R11 I2C disabled
    wbuf[0] = 8'h0C;
    spi_write(7'h23, 1);
    i2c_start();
    i2c_wr({PREFIX, 1'b0, 1'b0}, ack); check("R11 addr nack", ack, 0);
    i2c_wr(8'h00, ack);
    i2c_wr(8'hEE, ack);                check("R11 data nack", ack, 0);
    i2c_stop();
    spi_check("R11 reg unchanged", 7'h00, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule